// File: doc/BRIEF.md
# Power-fail guard with battery status check

This block sits between a host and a battery-backed static RAM. Two supply comparator flags drive it: one says the supply is above the full-operation level, the other says it has dropped below the write-protect level. Whenever the supply is not good, every memory strobe is forced inactive and the read data returned to the host is disabled (the tristate condition), whatever the host is doing.

Once the supply is good again, the block keeps the memory chip enable inactive for a recovery interval counted in clock cycles. It then checks the backup cell on its own. The memory inhibits the second access after a power restore when its cell is weak, so the block reads one location, writes the bitwise complement there, and reads it back. A mismatch means the cell is weak. The saved value is then written back whatever the outcome. A one-cycle completion pulse and a sticky bad-battery flag report the result. Host requests are blocked until the check finishes. If the supply fails during recovery or during the check, the block aborts without a result and starts again at the next restore.

Top module: `pwr_guard_bcheck`

## Requirements
- R1: While `supply_low` is 1 or `supply_ok` is 0, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `host_rdata_en` and `host_ready` are 0 in that same cycle, for any host input.
- R2: After protection ends (the first clock edge with `supply_ok`=1 and `supply_low`=0), `mem_ce_n` stays 1 for REC_CYCLES further cycles. The first check access starts in the next cycle, REC_CYCLES+1 edges after the restore.
- R3: The check makes four accesses in this order, all at address CHK_ADDR: read, write, read, write. Each access lasts ACC_CYCLES cycles with `mem_ce_n`=0, and one cycle with all strobes at 1 separates consecutive accesses. A read drives `mem_oe_n`=0 and `mem_we_n`=1. A write drives `mem_we_n`=0 and `mem_oe_n`=1.
- R4: The first write carries the bitwise complement of the data sampled in the last cycle of the first read. If the data sampled in the last cycle of the second read differs from that complement, `battery_bad` becomes 1. If it matches, `battery_bad` keeps its value.
- R5: The final write restores the saved data whatever the verify result. `check_done` is 1 for exactly one cycle, the cycle after the last restore-write cycle, and `battery_bad` shows the new result in that same cycle.
- R6: Once `battery_bad` is 1 it stays 1 until reset, across later power cycles and passing checks.
- R7: `host_ready` is 0 from reset or protection until the `check_done` cycle and 1 from then on. While it is 1, the host strobes pass straight through in the same cycle: `mem_ce_n`=!`host_sel`, `mem_addr`=`host_addr`, `mem_wdata`=`host_wdata`, and a read returns `mem_rdata` on `host_rdata` with `host_rdata_en`=1.
- R8: If `supply_low` rises or `supply_ok` falls during recovery or the check, the block returns to protection. `check_done` does not pulse and `battery_bad` does not change. The next restore waits the full recovery interval and runs the whole check again.
- R9: In normal operation, a fall of `supply_ok` while `supply_low` stays 0 only gates the strobes. When `supply_ok` returns, host access resumes in the same cycle and no new check runs. A rise of `supply_low` in normal operation does require a new recovery and check.
- R10: During and right after reset, all memory strobes are 1 and `battery_bad`, `check_done` and `host_ready` are 0.
- R11: A host request with both `host_wr` and `host_rd` set is a write: `mem_we_n`=0 and `mem_oe_n`=1. `mem_we_n` is never 0 while `mem_ce_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above the full-operation level |
| supply_low | input | 1 | Supply below the write-protect level |
| host_sel | input | 1 | Host access request (active high) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read (output enable) strobe |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data to host, zero when disabled |
| host_rdata_en | output | 1 | Host read data driven (0 means high impedance) |
| host_ready | output | 1 | Host requests are passed to memory |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| check_done | output | 1 | One-cycle pulse when the check completes |
| battery_bad | output | 1 | Sticky weak-battery flag |

## Verification
A wrong internal state shows up at the memory strobes within the same cycle. A recovery counter that is not cleared by an abort makes `mem_ce_n` fall earlier than REC_CYCLES+1 edges after the restore. A sequencer that skips or reorders a step puts the wrong strobe pattern or write data on the bus at a predictable cycle offset. A wrong saved register or comparison shows up in `battery_bad` in the `check_done` cycle, or as a restored value that differs from the preset one. The memory model in the bench inhibits the second access after a restore on request, so both verdicts and the mid-check abort are forced deliberately and compared cycle by cycle.

// File: rtl/pg_pkg.sv
package pg_pkg;

   typedef enum logic [3:0] {
      ST_PROT,
      ST_RECOV,
      ST_RD_SAVE,
      ST_GAP_A,
      ST_WR_CPL,
      ST_GAP_B,
      ST_RD_VER,
      ST_GAP_C,
      ST_WR_RST,
      ST_RUN
   } pg_state_e;

   typedef enum logic [1:0] {
      OP_IDLE,
      OP_READ,
      OP_WRITE
   } mem_op_e;

   function automatic logic is_access(input pg_state_e s);
      return (s == ST_RD_SAVE) || (s == ST_WR_CPL) || (s == ST_RD_VER) || (s == ST_WR_RST);
   endfunction

   function automatic mem_op_e op_of(input pg_state_e s);
      case (s)
         ST_RD_SAVE, ST_RD_VER: return OP_READ;
         ST_WR_CPL, ST_WR_RST:  return OP_WRITE;
         default:               return OP_IDLE;
      endcase
   endfunction

   function automatic pg_state_e step_of(input pg_state_e s);
      case (s)
         ST_RD_SAVE: return ST_GAP_A;
         ST_GAP_A:   return ST_WR_CPL;
         ST_WR_CPL:  return ST_GAP_B;
         ST_GAP_B:   return ST_RD_VER;
         ST_RD_VER:  return ST_GAP_C;
         ST_GAP_C:   return ST_WR_RST;
         ST_WR_RST:  return ST_RUN;
         default:    return ST_PROT;
      endcase
   endfunction

endpackage

// File: rtl/pg_recov_timer.sv
module pg_recov_timer #(
   parameter int REC_CYCLES = 8_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expired
);

   localparam int CW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES + 1) : 1;
   localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign expired = arm && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!arm) begin
         cnt_q <= '0;
      end else if (!expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pg_check_seq.sv
module pg_check_seq
   import pg_pkg::*;
#(
   parameter int DW         = 8,
   parameter int ACC_CYCLES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          supply_good,
   input  logic          supply_low,
   input  logic          rec_done,
   input  logic [DW-1:0] rd_data,
   output pg_state_e     state,
   output mem_op_e       chk_op,
   output logic [DW-1:0] chk_wdata,
   output logic          check_done,
   output logic          battery_bad
);

   localparam int ACW = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1;

   pg_state_e     st_q, st_d;
   logic          acc_last;
   logic          in_access;
   logic [DW-1:0] save_q;
   logic          mism_q;
   logic          done_q;
   logic          bad_q;
   logic          finish;

   assign in_access = is_access(st_q);

   generate
      if (ACC_CYCLES == 1) begin : g_single
         assign acc_last = 1'b1;
      end else begin : g_multi
         logic [ACW-1:0] acc_q;
         assign acc_last = (acc_q == ACW'(ACC_CYCLES - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (in_access && !acc_last) begin
               acc_q <= acc_q + 1'b1;
            end else begin
               acc_q <= '0;
            end
         end
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_PROT: begin
            if (supply_good) st_d = ST_RECOV;
         end
         ST_RECOV: begin
            if (!supply_good)  st_d = ST_PROT;
            else if (rec_done) st_d = ST_RD_SAVE;
         end
         ST_RUN: begin
            if (supply_low) st_d = ST_PROT;
         end
         ST_GAP_A, ST_GAP_B, ST_GAP_C: begin
            st_d = supply_good ? step_of(st_q) : ST_PROT;
         end
         ST_RD_SAVE, ST_WR_CPL, ST_RD_VER, ST_WR_RST: begin
            if (!supply_good)  st_d = ST_PROT;
            else if (acc_last) st_d = step_of(st_q);
         end
         default: st_d = ST_PROT;
      endcase
   end

   assign finish = (st_q == ST_WR_RST) && acc_last && supply_good;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_PROT;
         save_q <= '0;
         mism_q <= 1'b0;
         done_q <= 1'b0;
         bad_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= finish;
         if (finish && mism_q) bad_q <= 1'b1;
         if (st_q == ST_RECOV) mism_q <= 1'b0;
         if ((st_q == ST_RD_SAVE) && acc_last) save_q <= rd_data;
         if ((st_q == ST_RD_VER) && acc_last) mism_q <= (rd_data != ~save_q);
      end
   end

   assign state       = st_q;
   assign chk_op      = op_of(st_q);
   assign chk_wdata   = (st_q == ST_WR_CPL) ? ~save_q : save_q;
   assign check_done  = done_q;
   assign battery_bad = bad_q;

endmodule

// File: rtl/pg_bus_gate.sv
module pg_bus_gate
   import pg_pkg::*;
#(
   parameter int AW            = 17,
   parameter int DW            = 8,
   parameter int CHK_ADDR      = 0,
   parameter bit IDLE_BUS_ZERO = 1'b0
) (
   input  logic          supply_good,
   input  logic          run,
   input  mem_op_e       chk_op,
   input  logic [DW-1:0] chk_wdata,
   input  logic          host_sel,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_ce_n,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          host_rdata_en,
   output logic          host_ready
);

   localparam logic [AW-1:0] CHK_A = AW'(CHK_ADDR);

   logic pass_host;
   logic host_act;
   logic chk_act;
   logic host_read;
   logic [AW-1:0] idle_addr;
   logic [DW-1:0] idle_data;

   assign pass_host = run && supply_good;
   assign host_act  = pass_host && host_sel;
   assign chk_act   = (chk_op != OP_IDLE) && supply_good;
   assign host_read = host_act && host_rd && !host_wr;

   assign mem_ce_n = !(host_act || chk_act);
   assign mem_we_n = !((host_act && host_wr) || (chk_act && (chk_op == OP_WRITE)));
   assign mem_oe_n = !(host_read || (chk_act && (chk_op == OP_READ)));

   generate
      if (IDLE_BUS_ZERO) begin : g_quiet_bus
         assign idle_addr = host_act ? host_addr : '0;
         assign idle_data = host_act ? host_wdata : '0;
      end else begin : g_follow_bus
         assign idle_addr = host_addr;
         assign idle_data = host_wdata;
      end
   endgenerate

   assign mem_addr  = (chk_op != OP_IDLE) ? CHK_A : idle_addr;
   assign mem_wdata = (chk_op != OP_IDLE) ? chk_wdata : idle_data;

   assign host_rdata_en = host_read;
   assign host_rdata    = host_read ? mem_rdata : '0;
   assign host_ready    = pass_host;

endmodule

// File: rtl/pwr_guard_bcheck.sv
module pwr_guard_bcheck
   import pg_pkg::*;
#(
   parameter int AW            = 17,
   parameter int DW            = 8,
   parameter int REC_CYCLES    = 8_000_000,
   parameter int ACC_CYCLES    = 2,
   parameter int CHK_ADDR      = 0,
   parameter bit IDLE_BUS_ZERO = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          supply_ok,
   input  logic          supply_low,
   input  logic          host_sel,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          host_rdata_en,
   output logic          host_ready,
   output logic          mem_ce_n,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          check_done,
   output logic          battery_bad
);

   generate
      if (AW < 1 || AW > 32) begin : g_bad_aw
         $error("pwr_guard_bcheck: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("pwr_guard_bcheck: DW must be at least 1");
      end
      if (REC_CYCLES < 1) begin : g_bad_rec
         $error("pwr_guard_bcheck: REC_CYCLES must be at least 1");
      end
      if (ACC_CYCLES < 1) begin : g_bad_acc
         $error("pwr_guard_bcheck: ACC_CYCLES must be at least 1");
      end
      if (CHK_ADDR < 0 || longint'(CHK_ADDR) >= (64'd1 << AW)) begin : g_bad_addr
         $error("pwr_guard_bcheck: CHK_ADDR outside address space");
      end
   endgenerate

   logic          supply_good;
   logic          rec_done;
   pg_state_e     state;
   mem_op_e       chk_op;
   logic [DW-1:0] chk_wdata;

   assign supply_good = supply_ok && !supply_low;

   pg_recov_timer #(
      .REC_CYCLES(REC_CYCLES)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (state == ST_RECOV),
      .expired(rec_done)
   );

   pg_check_seq #(
      .DW        (DW),
      .ACC_CYCLES(ACC_CYCLES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .supply_good(supply_good),
      .supply_low (supply_low),
      .rec_done   (rec_done),
      .rd_data    (mem_rdata),
      .state      (state),
      .chk_op     (chk_op),
      .chk_wdata  (chk_wdata),
      .check_done (check_done),
      .battery_bad(battery_bad)
   );

   pg_bus_gate #(
      .AW           (AW),
      .DW           (DW),
      .CHK_ADDR     (CHK_ADDR),
      .IDLE_BUS_ZERO(IDLE_BUS_ZERO)
   ) u_gate (
      .supply_good  (supply_good),
      .run          (state == ST_RUN),
      .chk_op       (chk_op),
      .chk_wdata    (chk_wdata),
      .host_sel     (host_sel),
      .host_wr      (host_wr),
      .host_rd      (host_rd),
      .host_addr    (host_addr),
      .host_wdata   (host_wdata),
      .mem_rdata    (mem_rdata),
      .mem_ce_n     (mem_ce_n),
      .mem_we_n     (mem_we_n),
      .mem_oe_n     (mem_oe_n),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .host_rdata   (host_rdata),
      .host_rdata_en(host_rdata_en),
      .host_ready   (host_ready)
   );

endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk #(
   parameter int REC_CYCLES = 8
) (
   input logic clk,
   input logic rst_n,
   input logic supply_ok,
   input logic supply_low,
   input logic mem_ce_n,
   input logic mem_we_n,
   input logic mem_oe_n,
   input logic host_rdata_en,
   input logic host_ready,
   input logic check_done,
   input logic battery_bad
);

   localparam int QW = $clog2(REC_CYCLES + 2);

   // quiet_q: good-supply cycles since the last protection event
   // seen_q : a check has completed since then
   logic [QW-1:0] quiet_q;
   logic          seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= '0;
         seen_q  <= 1'b0;
      end else if (supply_low || (!supply_ok && !seen_q)) begin
         quiet_q <= '0;
         seen_q  <= 1'b0;
      end else begin
         if (check_done) seen_q <= 1'b1;
         if (quiet_q != {QW{1'b1}}) quiet_q <= quiet_q + 1'b1;
      end
   end

   assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_low || !supply_ok) |-> (mem_ce_n && mem_we_n && mem_oe_n && !host_rdata_en && !host_ready));

   assert_recovery_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !seen_q) |-> (quiet_q >= QW'(REC_CYCLES)));

   assert_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(battery_bad) |-> check_done);

   assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      check_done |-> $past(!mem_we_n && !mem_ce_n));

   assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      check_done |=> !check_done);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      battery_bad |=> battery_bad);

   assert_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_q && !check_done) |-> !host_ready);

   assert_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n));

endmodule

bind pwr_guard_bcheck pg_guard_chk #(
   .REC_CYCLES(REC_CYCLES)
) u_guard_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .supply_ok    (supply_ok),
   .supply_low   (supply_low),
   .mem_ce_n     (mem_ce_n),
   .mem_we_n     (mem_we_n),
   .mem_oe_n     (mem_oe_n),
   .host_rdata_en(host_rdata_en),
   .host_ready   (host_ready),
   .check_done   (check_done),
   .battery_bad  (battery_bad)
);

// File: tb/tb_pwr_guard_bcheck.sv
module tb_pwr_guard_bcheck;

   localparam int AW   = 4;
   localparam int DW   = 8;
   localparam int REC  = 20;
   localparam int ACC  = 2;
   localparam int CHKA = 5;
   localparam int LAST = REC + 1 + 4 * (ACC + 1) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0;
   logic supply_low = 1'b1;
   logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic host_rdata_en, host_ready;
   logic mem_ce_n, mem_we_n, mem_oe_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic check_done, battery_bad;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pwr_guard_bcheck #(
      .AW(AW), .DW(DW), .REC_CYCLES(REC), .ACC_CYCLES(ACC), .CHK_ADDR(CHKA), .IDLE_BUS_ZERO(1'b0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .supply_low(supply_low),
      .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rdata_en(host_rdata_en), .host_ready(host_ready),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .check_done(check_done), .battery_bad(battery_bad)
   );

   // memory model: async read, write on clock edge, optional weak-cell inhibit
   logic [DW-1:0] mem [16];
   logic model_bad = 1'b0;
   logic prev_ce = 1'b1;
   int   acc_cnt = 0;
   int   this_no;

   always_comb this_no = (prev_ce && !mem_ce_n) ? acc_cnt + 1 : acc_cnt;
   assign mem_rdata = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr] : 8'hFF;

   always @(posedge clk) begin
      if (supply_low) begin
         acc_cnt <= 0;
         prev_ce <= 1'b1;
      end else begin
         prev_ce <= mem_ce_n;
         if (prev_ce && !mem_ce_n) acc_cnt <= acc_cnt + 1;
      end
      if (!mem_ce_n && !mem_we_n && !(model_bad && this_no == 2))
         mem[mem_addr] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] strobes();
      return {mem_ce_n, mem_we_n, mem_oe_n};
   endfunction

   // Follows the check from the restore cycle (k=0) onwards; returns after k==stop_k.
   task automatic run_check(input logic [7:0] v, input bit prev_bad, input bit exp_bad, input int stop_k);
      for (int k = 0; k <= LAST + 1; k++) begin
         if (k > 0) @(negedge clk);
         #1;
         if (k <= REC) begin
            chk(strobes() == 3'b111, "R2 recovery strobes", strobes(), 3'b111);
         end else if (k < LAST) begin
            int ph = k - REC - 1;
            int an = ph / (ACC + 1);
            int off = ph % (ACC + 1);
            if (off == ACC) begin
               chk(strobes() == 3'b111, "R3 gap strobes", strobes(), 3'b111);
            end else if (an == 0 || an == 2) begin
               chk(strobes() == 3'b010 && mem_addr == CHKA, "R3 read access",
                   {strobes(), 4'h0, mem_addr}, {3'b010, 4'h0, 4'(CHKA)});
            end else begin
               logic [7:0] wexp = (an == 1) ? ~v : v;
               chk(strobes() == 3'b001 && mem_addr == CHKA, "R3 write access",
                   {strobes(), 4'h0, mem_addr}, {3'b001, 4'h0, 4'(CHKA)});
               chk(mem_wdata == wexp, (an == 1) ? "R4 complement data" : "R5 restore data",
                   mem_wdata, wexp);
            end
         end
         if (k < LAST) begin
            chk(!host_ready, "R7 blocked before done", host_ready, 0);
            chk(!check_done, "R5 no early done", check_done, 0);
            chk(battery_bad == prev_bad, "R4 flag before done", battery_bad, prev_bad);
         end else begin
            chk(host_ready, "R7 ready after check", host_ready, 1);
            chk(check_done == (k == LAST), "R5 done pulse", check_done, (k == LAST));
            chk(battery_bad == (prev_bad | exp_bad), "R4 verdict", battery_bad, prev_bad | exp_bad);
         end
         if (k == stop_k) return;
      end
   endtask

   task automatic power_down();
      @(negedge clk);
      supply_low = 1'b1;
      supply_ok  = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic raise();
      @(negedge clk);
      supply_low = 1'b0;
      supply_ok  = 1'b1;
   endtask

   task automatic host_idle();
      host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
   endtask

   task automatic host_write(input logic [3:0] a, input logic [7:0] d, input bit also_rd);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_rd = also_rd; host_addr = a; host_wdata = d;
      #1;
      chk(strobes() == 3'b001, also_rd ? "R11 write priority" : "R7 host write strobes", strobes(), 3'b001);
      chk(mem_addr == a && mem_wdata == d, "R7 host write bus", {mem_addr, mem_wdata}, {a, d});
   endtask

   task automatic host_read(input logic [3:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b0; host_rd = 1'b1; host_addr = a;
      #1;
      chk(host_rdata_en && host_rdata == exp && strobes() == 3'b010, req,
          {host_rdata_en, host_rdata}, {1'b1, exp});
   endtask

   task automatic run_all();
      for (int i = 0; i < 16; i++) mem[i] = 8'h00;

      // R10: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(strobes() == 3'b111, "R10 strobes in reset", strobes(), 3'b111);
      chk(!battery_bad && !check_done && !host_ready, "R10 flags in reset",
          {battery_bad, check_done, host_ready}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(strobes() == 3'b111 && !host_ready && !battery_bad, "R10 after reset",
          {strobes(), host_ready, battery_bad}, {3'b111, 2'b00});

      // R1: host requests while protected
      host_sel = 1'b1; host_wr = 1'b1; host_rd = 1'b0; host_addr = 4'd3; host_wdata = 8'h77;
      repeat (2) @(negedge clk);
      #1;
      chk(strobes() == 3'b111 && !host_rdata_en && !host_ready, "R1 protected gating",
          {strobes(), host_rdata_en, host_ready}, {3'b111, 2'b00});
      host_idle();

      // R8: supply_ok loss during recovery restarts the interval
      raise();
      repeat (10) @(negedge clk);
      supply_ok = 1'b0;
      #1;
      chk(strobes() == 3'b111 && !host_ready, "R8 dip in recovery", {strobes(), host_ready}, {3'b111, 1'b0});
      @(negedge clk);
      supply_ok = 1'b1;

      // R2/R3/R4/R5: first check with a healthy cell
      mem[CHKA] = 8'h3C;
      run_check(8'h3C, 1'b0, 1'b0, LAST + 1);
      chk(mem[CHKA] == 8'h3C, "R5 restored value", mem[CHKA], 8'h3C);

      // R7/R11: sweep all addresses through the host path
      for (int a = 0; a < 16; a++) host_write(4'(a), 8'(a * 29 + 7), 1'b0);
      for (int a = 0; a < 16; a++) host_read(4'(a), 8'(a * 29 + 7), "R7 host read");
      host_write(4'd9, 8'hC3, 1'b1);
      host_read(4'd9, 8'hC3, "R11 readback");
      @(negedge clk);
      host_idle();
      #1;
      chk(strobes() == 3'b111, "R7 idle host", strobes(), 3'b111);

      // R9: supply_ok dip in normal operation
      host_sel = 1'b1; host_rd = 1'b1; host_addr = 4'd2;
      supply_ok = 1'b0;
      #1;
      chk(strobes() == 3'b111 && !host_rdata_en && !host_ready, "R1 gated during dip",
          {strobes(), host_rdata_en, host_ready}, {3'b111, 2'b00});
      repeat (3) @(negedge clk);
      supply_ok = 1'b1;
      #1;
      chk(host_ready && host_rdata_en && host_rdata == 8'(2 * 29 + 7), "R9 resume without check",
          {host_ready, host_rdata_en, host_rdata}, {2'b11, 8'(2 * 29 + 7)});
      @(negedge clk);
      #1;
      chk(!check_done && host_ready, "R9 no new check", {check_done, host_ready}, 2'b01);
      host_idle();

      // R8: supply_low during the complement write aborts the check
      power_down();
      #1;
      chk(!host_ready, "R9 low forces protection", host_ready, 0);
      mem[CHKA] = 8'h96;
      model_bad = 1'b1;
      raise();
      run_check(8'h96, 1'b0, 1'b0, REC + 1 + (ACC + 1) + 1);
      supply_low = 1'b1;
      supply_ok  = 1'b0;
      #1;
      chk(strobes() == 3'b111, "R8 abort gating", strobes(), 3'b111);
      begin
         bit seen_done = 1'b0;
         for (int i = 0; i < REC + 20; i++) begin
            @(negedge clk);
            if (check_done || battery_bad) seen_done = 1'b1;
         end
         chk(!seen_done, "R8 no result after abort", seen_done, 0);
      end

      // R8: next restore runs the full check again
      model_bad = 1'b0;
      mem[CHKA] = 8'h5A;
      raise();
      run_check(8'h5A, 1'b0, 1'b0, LAST + 1);
      chk(mem[CHKA] == 8'h5A, "R8 rerun restored", mem[CHKA], 8'h5A);

      // R4: weak cell inhibits the second access
      power_down();
      mem[CHKA] = 8'hA5;
      model_bad = 1'b1;
      raise();
      run_check(8'hA5, 1'b0, 1'b1, LAST + 1);
      chk(mem[CHKA] == 8'hA5, "R5 restored after bad", mem[CHKA], 8'hA5);

      // R6: passing check leaves the flag set
      power_down();
      model_bad = 1'b0;
      mem[CHKA] = 8'h00;
      raise();
      run_check(8'h00, 1'b1, 1'b0, LAST + 1);
      chk(battery_bad, "R6 sticky flag", battery_bad, 1);
      host_read(4'(CHKA), 8'h00, "R7 read after sticky check");
      @(negedge clk);
      host_idle();
   endtask

   initial begin
      fork
         run_all();
         begin
            #2_000_000;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule